// File: doc/BRIEF.md
# Effective address generator

This block forms the 32-bit memory address for one load or store of a load-store processor. The decode stage supplies an addressing-mode code, the access size and all operand sources: the base register value, the R0 index value, the global base register, the program counter and the raw displacement field taken from the instruction word. The block adds the selected base and the selected offset. Offsets are scaled by the access size or, for branch targets, by two.

The modes that modify the base register also return the new base value and a write-back strobe, so the register file can update the register in the same cycle the address is used. All outputs are registered and appear one clock after a request is presented. Addresses wrap modulo 2^32.

Top module: `eag_unit`

## Requirements
- R1: While `rst` is high at a clock edge, `valid_o`, `wb_en_o`, `ea_o` and `rn_new_o` are all cleared to zero.
- R2: Mode code 0 (plain indirect) and the reserved mode codes 10 to 15 give `ea_o` = base, `rn_new_o` = base, and `wb_en_o` = 0.
- R3: Mode code 1 (post-increment) gives `ea_o` = base, `rn_new_o` = base + step, and `wb_en_o` = 1.
- R4: Mode code 2 (pre-decrement) gives `ea_o` = `rn_new_o` = base - step, and `wb_en_o` = 1.
- R5: The step and the displacement scale follow the size code: 0 byte gives 1, 1 word gives 2, 2 and 3 longword give 4.
- R6: Mode code 3 adds `disp_i[3:0]`, zero-extended and scaled by size, to the base. Bits 11:4 of the displacement are ignored.
- R7: Mode code 4 gives base + index. Mode code 6 gives global base + index.
- R8: Mode code 5 adds `disp_i[7:0]`, zero-extended and scaled by size, to the global base.
- R9: Mode code 7 (literal pool) adds `disp_i[7:0]`, zero-extended and scaled by size, to the PC. For the longword size, PC bits 1:0 are cleared before the add.
- R10: Mode code 8 adds the sign-extended `disp_i[7:0]` times 2 to the PC. Mode code 9 adds the sign-extended `disp_i[11:0]` times 2 to the PC.
- R11: A request with `valid_i` = 1 shows up on the outputs at the next clock edge with `valid_o` = 1. A request with `valid_i` = 0 gives `valid_o` = 0 and `wb_en_o` = 0.
- R12: Every sum and difference wraps modulo 2^32.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| valid_i | input | 1 | Request present |
| mode_i | input | 4 | Addressing-mode code |
| size_i | input | 2 | Access size code |
| rn_i | input | 32 | Base register value |
| r0_i | input | 32 | Index register value |
| gbr_i | input | 32 | Global base register value |
| pc_i | input | 32 | Program counter |
| disp_i | input | 12 | Raw displacement field |
| valid_o | output | 1 | Result valid |
| ea_o | output | 32 | Effective address |
| rn_new_o | output | 32 | Updated base register value |
| wb_en_o | output | 1 | Base register write-back strobe |

## Verification
The hardest cases to reach are the wrap-around and sign corners. These are a pre-decrement from base zero, an index sum that overflows to exactly zero, and branch displacements at the most negative and most positive 12-bit values. Only specific operand values produce them. The bench builds each corner with hand-chosen operands. It also feeds displacements with junk in the upper bits and a longword literal load from a PC that is not aligned, to show that the masking and alignment rules take effect.

// File: rtl/eag_pkg.sv
package eag_pkg;

    localparam int AW = 32;

    typedef enum logic [3:0] {
        M_IND     = 4'd0,
        M_POSTINC = 4'd1,
        M_PREDEC  = 4'd2,
        M_DISP4   = 4'd3,
        M_IDX_RN  = 4'd4,
        M_GBR8    = 4'd5,
        M_IDX_GBR = 4'd6,
        M_PCLIT   = 4'd7,
        M_BR8     = 4'd8,
        M_BR12    = 4'd9
    } mode_e;

    typedef struct packed {
        logic [AW-1:0] base;
        logic [AW-1:0] offset;
    } addr_terms_t;

    typedef struct packed {
        logic [AW-1:0] rn_new;
        logic          wb;
    } wb_t;

    function automatic logic [1:0] size_shift(input logic [1:0] sz);
        return (sz[1]) ? 2'd2 : sz;
    endfunction

endpackage

// File: rtl/eag_operand_sel.sv
module eag_operand_sel
    import eag_pkg::*;
#(
    parameter int DISP_W        = 12,
    parameter bit CLEAR_PC_LONG = 1'b1
) (
    input  logic [3:0]        mode,
    input  logic [1:0]        size,
    input  logic [AW-1:0]     rn,
    input  logic [AW-1:0]     r0,
    input  logic [AW-1:0]     gbr,
    input  logic [AW-1:0]     pc,
    input  logic [DISP_W-1:0] disp,
    output addr_terms_t       terms
);
    localparam int SHORT_W = 4;
    localparam int BYTE_W  = 8;

    logic [1:0]    shamt;
    logic [AW-1:0] step;
    logic [AW-1:0] d_short;
    logic [AW-1:0] d_byte;
    logic [AW-1:0] br_short;
    logic [AW-1:0] br_long;
    logic [AW-1:0] pc_lit_base;

    assign shamt    = size_shift(size);
    assign step     = AW'(1) << shamt;
    assign d_short  = AW'(disp[SHORT_W-1:0]) << shamt;
    assign d_byte   = AW'(disp[BYTE_W-1:0]) << shamt;
    assign br_short = AW'(signed'(disp[BYTE_W-1:0])) << 1;
    assign br_long  = AW'(signed'(disp[DISP_W-1:0])) << 1;

    generate
        if (CLEAR_PC_LONG) begin : g_pc_align
            assign pc_lit_base = (shamt == 2'd2) ? {pc[AW-1:2], 2'b00} : pc;
        end else begin : g_pc_raw
            assign pc_lit_base = pc;
        end
    endgenerate

    always_comb begin
        terms.base   = rn;
        terms.offset = '0;
        case (mode_e'(mode))
            M_PREDEC:  terms.offset = '0 - step;
            M_DISP4:   terms.offset = d_short;
            M_IDX_RN:  terms.offset = r0;
            M_GBR8:    begin terms.base = gbr; terms.offset = d_byte; end
            M_IDX_GBR: begin terms.base = gbr; terms.offset = r0;     end
            M_PCLIT:   begin terms.base = pc_lit_base; terms.offset = d_byte; end
            M_BR8:     begin terms.base = pc; terms.offset = br_short; end
            M_BR12:    begin terms.base = pc; terms.offset = br_long;  end
            default:   ;
        endcase
    end
endmodule

// File: rtl/eag_writeback.sv
module eag_writeback
    import eag_pkg::*;
(
    input  logic [3:0]    mode,
    input  logic [1:0]    size,
    input  logic [AW-1:0] rn,
    output wb_t           wb
);
    logic [AW-1:0] step;

    assign step = AW'(1) << size_shift(size);

    always_comb begin
        wb.rn_new = rn;
        wb.wb     = 1'b0;
        case (mode_e'(mode))
            M_POSTINC: begin wb.rn_new = rn + step; wb.wb = 1'b1; end
            M_PREDEC:  begin wb.rn_new = rn - step; wb.wb = 1'b1; end
            default:   ;
        endcase
    end
endmodule

// File: rtl/eag_unit.sv
module eag_unit
    import eag_pkg::*;
#(
    parameter int DISP_W        = 12,
    parameter bit CLEAR_PC_LONG = 1'b1
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              valid_i,
    input  logic [3:0]        mode_i,
    input  logic [1:0]        size_i,
    input  logic [AW-1:0]     rn_i,
    input  logic [AW-1:0]     r0_i,
    input  logic [AW-1:0]     gbr_i,
    input  logic [AW-1:0]     pc_i,
    input  logic [DISP_W-1:0] disp_i,
    output logic              valid_o,
    output logic [AW-1:0]     ea_o,
    output logic [AW-1:0]     rn_new_o,
    output logic              wb_en_o
);
    addr_terms_t   terms;
    wb_t           wbv;
    logic [AW-1:0] ea_comb;

    eag_operand_sel #(
        .DISP_W       (DISP_W),
        .CLEAR_PC_LONG(CLEAR_PC_LONG)
    ) u_sel (
        .mode (mode_i),
        .size (size_i),
        .rn   (rn_i),
        .r0   (r0_i),
        .gbr  (gbr_i),
        .pc   (pc_i),
        .disp (disp_i),
        .terms(terms)
    );

    eag_writeback u_wb (
        .mode(mode_i),
        .size(size_i),
        .rn  (rn_i),
        .wb  (wbv)
    );

    assign ea_comb = terms.base + terms.offset;

    always_ff @(posedge clk) begin
        if (rst) begin
            valid_o  <= 1'b0;
            wb_en_o  <= 1'b0;
            ea_o     <= '0;
            rn_new_o <= '0;
        end else begin
            valid_o <= valid_i;
            wb_en_o <= valid_i & wbv.wb;
            if (valid_i) begin
                ea_o     <= ea_comb;
                rn_new_o <= wbv.rn_new;
            end
        end
    end

    AST_WB_NEEDS_VALID: assert property (@(posedge clk) disable iff (rst)
        wb_en_o |-> valid_o); // R11
    AST_POSTINC_ADDR: assert property (@(posedge clk) disable iff (rst)
        (valid_o && $past(mode_i) == 4'd1) |-> (ea_o == $past(rn_i) && wb_en_o)); // R3
    AST_PREDEC_SAME: assert property (@(posedge clk) disable iff (rst)
        (valid_o && $past(mode_i) == 4'd2) |-> (ea_o == rn_new_o && wb_en_o)); // R4
    AST_PLAIN_NO_WB: assert property (@(posedge clk) disable iff (rst)
        (valid_o && $past(mode_i) == 4'd0) |-> (!wb_en_o && ea_o == $past(rn_i))); // R2
    AST_LONG_LIT_ALIGN: assert property (@(posedge clk) disable iff (rst)
        (valid_o && $past(mode_i) == 4'd7 && $past(size_i[1])) |-> (ea_o[1:0] == 2'b00)); // R9
    AST_BR_EVEN: assert property (@(posedge clk) disable iff (rst)
        (valid_o && ($past(mode_i) == 4'd8 || $past(mode_i) == 4'd9) && !$past(pc_i[0]))
            |-> !ea_o[0]); // R10
endmodule

// File: tb/eag_unit_bench.sv
module eag_unit_bench;
    logic        clk = 1'b0;
    logic        rst;
    logic        valid_i;
    logic [3:0]  mode_i;
    logic [1:0]  size_i;
    logic [31:0] rn_i, r0_i, gbr_i, pc_i;
    logic [11:0] disp_i;
    logic        valid_o;
    logic [31:0] ea_o, rn_new_o;
    logic        wb_en_o;

    int checks = 0;
    int errors = 0;

    always #2 clk = ~clk;

    eag_unit u_eag_unit (
        .clk(clk), .rst(rst), .valid_i(valid_i), .mode_i(mode_i), .size_i(size_i),
        .rn_i(rn_i), .r0_i(r0_i), .gbr_i(gbr_i), .pc_i(pc_i), .disp_i(disp_i),
        .valid_o(valid_o), .ea_o(ea_o), .rn_new_o(rn_new_o), .wb_en_o(wb_en_o)
    );

    task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s: actual=%h expected=%h", req, act, exp);
        end
    endtask

    // Present one request at a falling edge, sample after the capturing rising edge.
    task automatic issue(input logic v, input logic [3:0] m, input logic [1:0] s,
                         input logic [31:0] rn, input logic [31:0] r0, input logic [31:0] gbr,
                         input logic [31:0] pc, input logic [11:0] d);
        @(negedge clk);
        valid_i = v; mode_i = m; size_i = s;
        rn_i = rn; r0_i = r0; gbr_i = gbr; pc_i = pc; disp_i = d;
        @(negedge clk);
    endtask

    task automatic expect_out(input string req, input logic [31:0] ea, input logic [31:0] rnn,
                              input logic wb);
        check({req, " valid"}, {31'd0, valid_o}, 32'd1);
        check({req, " ea"}, ea_o, ea);
        check({req, " rn_new"}, rn_new_o, rnn);
        check({req, " wb"}, {31'd0, wb_en_o}, {31'd0, wb});
    endtask

    task automatic t_reset;
        rst = 1'b1;
        valid_i = 1'b1; mode_i = 4'd1; size_i = 2'd2;
        rn_i = 32'h55; r0_i = 0; gbr_i = 0; pc_i = 0; disp_i = 0;
        repeat (3) @(negedge clk);
        check("R1 valid", {31'd0, valid_o}, 32'd0);
        check("R1 wb", {31'd0, wb_en_o}, 32'd0);
        check("R1 ea", ea_o, 32'd0);
        check("R1 rn_new", rn_new_o, 32'd0);
        rst = 1'b0;
    endtask

    task automatic t_plain;
        issue(1, 4'd0, 2'd2, 32'h1000_0040, 32'h7, 32'h9, 32'hA, 12'hFFF);
        expect_out("R2 plain", 32'h1000_0040, 32'h1000_0040, 1'b0);
        issue(1, 4'd12, 2'd0, 32'h0000_ABCD, 32'h7, 32'h9, 32'hA, 12'h123);
        expect_out("R2 reserved", 32'h0000_ABCD, 32'h0000_ABCD, 1'b0);
    endtask

    task automatic t_postinc;
        issue(1, 4'd1, 2'd0, 32'h100, 0, 0, 0, 0);
        expect_out("R3 R5 byte", 32'h100, 32'h101, 1'b1);
        issue(1, 4'd1, 2'd1, 32'h100, 0, 0, 0, 0);
        expect_out("R3 R5 word", 32'h100, 32'h102, 1'b1);
        issue(1, 4'd1, 2'd2, 32'h100, 0, 0, 0, 0);
        expect_out("R3 R5 long", 32'h100, 32'h104, 1'b1);
        issue(1, 4'd1, 2'd3, 32'h100, 0, 0, 0, 0);
        expect_out("R5 size3", 32'h100, 32'h104, 1'b1);
    endtask

    task automatic t_predec;
        issue(1, 4'd2, 2'd2, 32'h2000, 0, 0, 0, 0);
        expect_out("R4 long", 32'h1FFC, 32'h1FFC, 1'b1);
        issue(1, 4'd2, 2'd0, 32'h0, 0, 0, 0, 0);
        expect_out("R4 R12 wrap", 32'hFFFF_FFFF, 32'hFFFF_FFFF, 1'b1);
    endtask

    task automatic t_disp4;
        issue(1, 4'd3, 2'd2, 32'h3000, 0, 0, 0, 12'hFF5);
        expect_out("R6 long", 32'h3014, 32'h3000, 1'b0);
        issue(1, 4'd3, 2'd1, 32'h3000, 0, 0, 0, 12'hFF5);
        expect_out("R6 word", 32'h300A, 32'h3000, 1'b0);
        issue(1, 4'd3, 2'd0, 32'h3000, 0, 0, 0, 12'hFF5);
        expect_out("R6 byte", 32'h3005, 32'h3000, 1'b0);
    endtask

    task automatic t_index;
        issue(1, 4'd4, 2'd2, 32'h10, 32'hFFFF_FFF0, 32'h8000, 0, 12'hFFF);
        expect_out("R7 R12 rn+r0", 32'h0, 32'h10, 1'b0);
        issue(1, 4'd6, 2'd0, 32'h10, 32'h24, 32'h8000, 0, 12'hFFF);
        expect_out("R7 gbr+r0", 32'h8024, 32'h10, 1'b0);
    endtask

    task automatic t_gbr;
        issue(1, 4'd5, 2'd1, 32'h0, 32'h0, 32'h8000, 0, 12'hF80);
        expect_out("R8 word", 32'h8100, 32'h0, 1'b0);
        issue(1, 4'd5, 2'd2, 32'h0, 32'h0, 32'h8000, 0, 12'hF80);
        expect_out("R8 long", 32'h8200, 32'h0, 1'b0);
    endtask

    task automatic t_pclit;
        issue(1, 4'd7, 2'd1, 32'h0, 0, 0, 32'h1002, 12'h010);
        expect_out("R9 word", 32'h1022, 32'h0, 1'b0);
        issue(1, 4'd7, 2'd2, 32'h0, 0, 0, 32'h1002, 12'h010);
        expect_out("R9 long aligned", 32'h1040, 32'h0, 1'b0);
        issue(1, 4'd7, 2'd0, 32'h0, 0, 0, 32'h1002, 12'hF10);
        expect_out("R9 byte", 32'h1012, 32'h0, 1'b0);
    endtask

    task automatic t_branch;
        issue(1, 4'd8, 2'd0, 32'h0, 0, 0, 32'h4000, 12'h0FE);
        expect_out("R10 br8 neg", 32'h3FFC, 32'h0, 1'b0);
        issue(1, 4'd9, 2'd0, 32'h0, 0, 0, 32'h4000, 12'h800);
        expect_out("R10 br12 min", 32'h3000, 32'h0, 1'b0);
        issue(1, 4'd9, 2'd0, 32'h0, 0, 0, 32'h4000, 12'h7FF);
        expect_out("R10 br12 max", 32'h4FFE, 32'h0, 1'b0);
    endtask

    task automatic t_gating;
        issue(0, 4'd1, 2'd2, 32'h500, 0, 0, 0, 0);
        check("R11 idle valid", {31'd0, valid_o}, 32'd0);
        check("R11 idle wb", {31'd0, wb_en_o}, 32'd0);
        // Latency: result must be present one edge after the request, not before.
        @(negedge clk);
        valid_i = 1'b1; mode_i = 4'd0; rn_i = 32'h777;
        #1;
        check("R11 not early", {31'd0, valid_o}, 32'd0);
        @(negedge clk);
        check("R11 one cycle", ea_o, 32'h777);
        valid_i = 1'b0;
    endtask

    initial begin
        fork
            begin
                t_reset();
                t_plain();
                t_postinc();
                t_predec();
                t_disp4();
                t_index();
                t_gbr();
                t_pclit();
                t_branch();
                t_gating();
            end
            begin
                repeat (20000) @(posedge clk);
                errors++;
                checks++;
                $display("FAIL watchdog: actual=timeout expected=done");
            end
        join_any
        disable fork;
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end
endmodule